// File: doc/BRIEF.md
# Write-Bubble Table Updater for a Pipelined Search Tree

This block changes the node memories of a pipelined tree-search engine without stopping the lookup stream. Each pipeline stage owns one node memory, which holds one level of the tree. Each stage also owns a small update table. The table has one entry per bubble identifier, and every entry holds two write slots (port 0 and port 1). A slot carries a write-enable bit, a node address and a new node word. Software fills these tables in advance through a load interface, one slot per request. It then injects a bubble that carries an identifier. The bubble takes one slot in the stream and walks down the pipeline. As it enters stage j, the enabled slots of entry `bubbleId` in table j are written into memory j, both ports in the same cycle. Lookups in front of the bubble therefore see the old tree at every level, and lookups behind it see the new one.

To keep the datapath observable without a full search, each lookup is a probe. Its key gives one node address per stage, and its result gathers the node word read at each stage. Computing new tree contents and comparing keys against nodes are outside this block.

Top module: `wbubble_updater`

## Requirements
- R1: After reset, `resultValid` is low and every node word in every stage memory reads as zero. Every table slot has its write-enable cleared.
- R2: A lookup presented with `lookupValid` high (and `bubbleReq` low) before rising edge e produces `resultValid` high right after edge e+NUM_STAGES. Results come out in input order. Field j of `resultData` (bits j*NODE_W upward) holds the word at the address in field j of `lookupKey` (bits j*ADDR_W upward) of stage memory j.
- R3: A bubble injected with identifier i before edge e writes each enabled slot of table j, entry i, into stage memory j at edge e+j. Both slots of one entry are written in the same cycle.
- R4: Every lookup injected before a bubble sees the memory contents without that bubble's writes at all stages. Every lookup injected after it sees them with the writes at all stages. No lookup is stalled.
- R5: A table slot whose write-enable bit is 0 leaves the stage memory unchanged when a bubble passes.
- R6: A bubble occupies one stream slot. If `lookupValid` and `bubbleReq` are high together, the bubble wins, that lookup is dropped and no result is produced for that slot.
- R7: A load to stage j is rejected (`loadAck` low, table unchanged) when a bubble injected before edge c is loaded at edge e with c <= e <= c+j. This includes a bubble injected in the same cycle. Otherwise a valid load is accepted (`loadAck` high, combinational) and written at that edge.
- R8: Entries are selected by bubble identifier, so bubbles with different identifiers apply different contents. Several bubbles may be in flight, back to back.
- R9: When both slots of one entry target the same address, the port 1 word is the one that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A probe lookup is presented this cycle |
| lookupKey | input | NUM_STAGES*ADDR_W | Node address per stage, stage j at bits j*ADDR_W |
| bubbleReq | input | 1 | Inject an update bubble this cycle |
| bubbleId | input | ID_W | Identifier of the injected bubble |
| loadValid | input | 1 | Table slot load request |
| loadStage | input | STAGE_W | Stage whose table is loaded |
| loadId | input | ID_W | Entry (bubble identifier) loaded |
| loadPort | input | 1 | Slot within the entry, 0 or 1 |
| loadWe | input | 1 | Write-enable bit stored in the slot |
| loadAddr | input | ADDR_W | Node address stored in the slot |
| loadData | input | NODE_W | Node word stored in the slot |
| loadAck | output | 1 | Load accepted this cycle |
| resultValid | output | 1 | A lookup result is present |
| resultData | output | NUM_STAGES*NODE_W | Node word read per stage, stage j at bits j*NODE_W |

## Verification
A lookup is driven on a falling edge, and its result is checked on the falling edge after NUM_STAGES+1 rising edges. The bench tags every expectation with the edge count at which the lookup was captured, so both the order and the exact latency are checked. `loadAck` is combinational and is sampled one nanosecond after the inputs change, inside the same cycle. The bench applies a bubble's whole set of writes to its memory model at the moment of injection. It computes each lookup's expectation from the model at the lookup's own injection time. This is valid only if the design keeps the old/new ordering at every level, which is what the checks test. Load acceptance is predicted from the recorded injection edges of all bubbles.

// File: rtl/wbupd_pkg.sv
package wbupd_pkg;
  // Stream slot decision passed from control to datapath each cycle.
  typedef struct packed {
    logic takeLookup;    // a lookup enters stage 0 at this edge
    logic injectBubble;  // a bubble enters stage 0 at this edge
  } slotCtl_t;
endpackage

// File: rtl/wbu_ctrl.sv
module wbu_ctrl
  import wbupd_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int NUM_IDS    = 2,
  parameter int ADDR_W     = 3,
  parameter int NODE_W     = 8,
  parameter int ID_W       = 1,
  parameter int STAGE_W    = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      lookupValid,
  input  logic                                      bubbleReq,
  input  logic [ID_W-1:0]                           bubbleId,
  input  logic                                      loadValid,
  input  logic [STAGE_W-1:0]                        loadStage,
  input  logic [ID_W-1:0]                           loadId,
  input  logic                                      loadPort,
  input  logic                                      loadWe,
  input  logic [ADDR_W-1:0]                         loadAddr,
  input  logic [NODE_W-1:0]                         loadData,
  output logic                                      loadAck,
  output slotCtl_t                                  slotCtl,
  output logic [NUM_STAGES-1:0][1:0]                wrEn,
  output logic [NUM_STAGES-1:0][1:0][ADDR_W-1:0]    wrAddr,
  output logic [NUM_STAGES-1:0][1:0][NODE_W-1:0]    wrData
);

  // Update tables: stage x entry x slot
  logic [NUM_STAGES-1:0][NUM_IDS-1:0][1:0]              tWe;
  logic [NUM_STAGES-1:0][NUM_IDS-1:0][1:0][ADDR_W-1:0]  tAddr;
  logic [NUM_STAGES-1:0][NUM_IDS-1:0][1:0][NODE_W-1:0]  tData;

  // Bubble position tracking, one flag per pipeline stage
  logic [NUM_STAGES-1:0]            bubV;
  logic [NUM_STAGES-1:0][ID_W-1:0]  bubId;

  // Bubble arriving at each stage this cycle
  logic [NUM_STAGES-1:0]            inV;
  logic [NUM_STAGES-1:0][ID_W-1:0]  inId;

  logic stageInRange;
  logic tableBusy;

  assign slotCtl.injectBubble = bubbleReq;
  assign slotCtl.takeLookup   = lookupValid & ~bubbleReq;

  // Table j is still needed by any bubble that has not yet entered stage j
  always_comb begin
    tableBusy = bubbleReq;
    for (int i = 0; i < NUM_STAGES; i++) begin
      if (bubV[i] && (i < int'(loadStage))) tableBusy = 1'b1;
    end
  end

  assign stageInRange = int'(loadStage) < NUM_STAGES;
  assign loadAck      = loadValid & stageInRange & ~tableBusy;

  genvar g, p;
  generate
    for (g = 0; g < NUM_STAGES; g++) begin : gStage
      if (g == 0) begin : gRoot
        assign inV[g]  = bubbleReq;
        assign inId[g] = bubbleId;
      end else begin : gInner
        assign inV[g]  = bubV[g-1];
        assign inId[g] = bubId[g-1];
      end
      for (p = 0; p < 2; p++) begin : gPort
        assign wrEn[g][p]   = inV[g] & tWe[g][inId[g]][p];
        assign wrAddr[g][p] = tAddr[g][inId[g]][p];
        assign wrData[g][p] = tData[g][inId[g]][p];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bubV  <= '0;
      bubId <= '0;
    end else begin
      bubV  <= {bubV[NUM_STAGES-2:0], bubbleReq};
      bubId <= {bubId[NUM_STAGES-2:0], bubbleId};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tWe   <= '0;
      tAddr <= '0;
      tData <= '0;
    end else if (loadAck) begin
      tWe[loadStage][loadId][loadPort]   <= loadWe;
      tAddr[loadStage][loadId][loadPort] <= loadAddr;
      tData[loadStage][loadId][loadPort] <= loadData;
    end
  end

  // R7: a rejected load leaves every table slot as it was
  assert_reject_keeps_table_R7: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !loadAck) |=> ($stable(tWe) && $stable(tAddr) && $stable(tData)));

  generate
    for (g = 0; g < NUM_STAGES - 1; g++) begin : gAdv
      // R4: a bubble advances one stage per cycle and keeps its identifier
      assert_bubble_advances_R4: assert property (@(posedge clk) disable iff (!rstN)
        bubV[g] |=> (bubV[g+1] && (bubId[g+1] == $past(bubId[g]))));
    end
  endgenerate

endmodule

// File: rtl/wbu_datapath.sv
module wbu_datapath
  import wbupd_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int ADDR_W     = 3,
  parameter int NODE_W     = 8
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  slotCtl_t                                  slotCtl,
  input  logic [NUM_STAGES*ADDR_W-1:0]              lookupKey,
  input  logic [NUM_STAGES-1:0][1:0]                wrEn,
  input  logic [NUM_STAGES-1:0][1:0][ADDR_W-1:0]    wrAddr,
  input  logic [NUM_STAGES-1:0][1:0][NODE_W-1:0]    wrData,
  output logic                                      resultValid,
  output logic [NUM_STAGES*NODE_W-1:0]              resultData
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int KEY_W  = NUM_STAGES * ADDR_W;
  localparam int DATA_W = NUM_STAGES * NODE_W;

  logic [NUM_STAGES-1:0]             lkV;
  logic [NUM_STAGES-1:0][KEY_W-1:0]  lkKey;
  logic [NUM_STAGES-1:0][DATA_W-1:0] lkData;
  logic [NUM_STAGES-1:0][DATA_W-1:0] stageOut;

  genvar g;
  generate
    for (g = 0; g < NUM_STAGES; g++) begin : gStage
      logic [DEPTH-1:0][NODE_W-1:0] mem;
      logic [NODE_W-1:0]            readWord;

      assign readWord = mem[lkKey[g][g*ADDR_W +: ADDR_W]];
      assign stageOut[g] = (lkData[g] & ~(DATA_W'({NODE_W{1'b1}}) << (g*NODE_W)))
                         | (DATA_W'(readWord) << (g*NODE_W));

      // Port 1 is written after port 0, so it wins on an address clash
      always_ff @(posedge clk) begin
        if (!rstN) begin
          mem <= '0;
        end else begin
          if (wrEn[g][0]) mem[wrAddr[g][0]] <= wrData[g][0];
          if (wrEn[g][1]) mem[wrAddr[g][1]] <= wrData[g][1];
        end
      end

      // R3: a port-0 write without a clashing port-1 write lands as given
      assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn[g][0] && !(wrEn[g][1] && (wrAddr[g][1] == wrAddr[g][0])))
          |=> (mem[$past(wrAddr[g][0])] == $past(wrData[g][0])));

      // R9: a port-1 write always lands as given
      assert_port1_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
        wrEn[g][1] |=> (mem[$past(wrAddr[g][1])] == $past(wrData[g][1])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkV         <= '0;
      lkKey       <= '0;
      lkData      <= '0;
      resultValid <= 1'b0;
      resultData  <= '0;
    end else begin
      lkV[0]    <= slotCtl.takeLookup;
      lkKey[0]  <= lookupKey;
      lkData[0] <= '0;
      for (int j = 1; j < NUM_STAGES; j++) begin
        lkV[j]    <= lkV[j-1];
        lkKey[j]  <= lkKey[j-1];
        lkData[j] <= stageOut[j-1];
      end
      resultValid <= lkV[NUM_STAGES-1];
      resultData  <= stageOut[NUM_STAGES-1];
    end
  end

  // R6: a bubble slot never turns into a lookup in stage 0
  assert_bubble_no_lookup_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(slotCtl.injectBubble) |-> !lkV[0]);

  // R2: a result only follows a lookup held in the last stage
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(lkV[NUM_STAGES-1]));

endmodule

// File: rtl/wbubble_updater.sv
module wbubble_updater
  import wbupd_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int NUM_IDS    = 2,
  parameter int ADDR_W     = 3,
  parameter int NODE_W     = 8,
  localparam int ID_W      = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
  localparam int STAGE_W   = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lookupValid,
  input  logic [NUM_STAGES*ADDR_W-1:0]   lookupKey,
  input  logic                           bubbleReq,
  input  logic [ID_W-1:0]                bubbleId,
  input  logic                           loadValid,
  input  logic [STAGE_W-1:0]             loadStage,
  input  logic [ID_W-1:0]                loadId,
  input  logic                           loadPort,
  input  logic                           loadWe,
  input  logic [ADDR_W-1:0]              loadAddr,
  input  logic [NODE_W-1:0]              loadData,
  output logic                           loadAck,
  output logic                           resultValid,
  output logic [NUM_STAGES*NODE_W-1:0]   resultData
);

  slotCtl_t                                  slotCtl;
  logic [NUM_STAGES-1:0][1:0]                wrEn;
  logic [NUM_STAGES-1:0][1:0][ADDR_W-1:0]    wrAddr;
  logic [NUM_STAGES-1:0][1:0][NODE_W-1:0]    wrData;

  wbu_ctrl #(
    .NUM_STAGES(NUM_STAGES), .NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W),
    .NODE_W(NODE_W), .ID_W(ID_W), .STAGE_W(STAGE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid),
    .bubbleReq(bubbleReq), .bubbleId(bubbleId),
    .loadValid(loadValid), .loadStage(loadStage), .loadId(loadId),
    .loadPort(loadPort), .loadWe(loadWe), .loadAddr(loadAddr),
    .loadData(loadData), .loadAck(loadAck), .slotCtl(slotCtl),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  wbu_datapath #(
    .NUM_STAGES(NUM_STAGES), .ADDR_W(ADDR_W), .NODE_W(NODE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .slotCtl(slotCtl), .lookupKey(lookupKey),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .resultValid(resultValid), .resultData(resultData)
  );

endmodule

// File: tb/wbubble_updater_tb.sv
`timescale 1ns/1ps
module wbubble_updater_tb_top;
  localparam int NS = 4;
  localparam int AW = 3;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rstN;
  logic lookupValid;
  logic [NS*AW-1:0] lookupKey;
  logic bubbleReq;
  logic [0:0] bubbleId;
  logic loadValid;
  logic [1:0] loadStage;
  logic [0:0] loadId;
  logic loadPort, loadWe;
  logic [AW-1:0] loadAddr;
  logic [NW-1:0] loadData;
  logic loadAck, resultValid;
  logic [NS*NW-1:0] resultData;

  always #5 clk = ~clk;

  wbubble_updater dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupKey(lookupKey),
    .bubbleReq(bubbleReq), .bubbleId(bubbleId), .loadValid(loadValid),
    .loadStage(loadStage), .loadId(loadId), .loadPort(loadPort),
    .loadWe(loadWe), .loadAddr(loadAddr), .loadData(loadData),
    .loadAck(loadAck), .resultValid(resultValid), .resultData(resultData)
  );

  int checks = 0, fails = 0, edgeCnt = 0;
  bit done = 0, monOn = 0;

  // Bench model: node memories and update tables
  logic [NW-1:0] mm [NS][8];
  bit            mtWe [NS][2][2];
  int            mtAddr [NS][2][2];
  logic [NW-1:0] mtData [NS][2][2];
  logic [NS*NW-1:0] expQ [0:1023];
  int    expEdge [0:1023];
  string expTag [0:1023];
  int wrP = 0, rdP = 0;
  int bubEdge [0:255];
  int nBub = 0;

  always @(posedge clk) edgeCnt++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NS*AW-1:0] mkKey(input int a);
    logic [NS*AW-1:0] k;
    for (int j = 0; j < NS; j++) k[j*AW +: AW] = AW'((a + j) & 7);
    return k;
  endfunction

  task automatic step(input bit lk, input logic [NS*AW-1:0] key, input bit bb, input bit bid,
                      input bit ld, input int lst, input bit lid, input bit lpt, input bit lwe,
                      input int la, input int ldat, input string tag);
    int e;
    bit expAck;
    logic [NS*NW-1:0] r;
    e = edgeCnt + 1;
    lookupValid = lk; lookupKey = key; bubbleReq = bb; bubbleId = bid;
    loadValid = ld; loadStage = 2'(lst); loadId = lid; loadPort = lpt;
    loadWe = lwe; loadAddr = AW'(la); loadData = NW'(ldat);
    if (bb) begin
      for (int j = 0; j < NS; j++)
        for (int p = 0; p < 2; p++)
          if (mtWe[j][bid][p]) mm[j][mtAddr[j][bid][p]] = mtData[j][bid][p];
      bubEdge[nBub] = e; nBub++;
    end
    if (ld) begin
      expAck = 1;
      for (int i = 0; i < nBub; i++)
        if (e >= bubEdge[i] && e <= bubEdge[i] + lst) expAck = 0;
      #1;
      check(loadAck == expAck, {tag, " R7 loadAck"}, 32'(loadAck), 32'(expAck));
      if (expAck) begin
        mtWe[lst][lid][lpt] = lwe; mtAddr[lst][lid][lpt] = la; mtData[lst][lid][lpt] = NW'(ldat);
      end
    end
    if (lk && !bb) begin
      for (int j = 0; j < NS; j++) r[j*NW +: NW] = mm[j][key[j*AW +: AW]];
      expQ[wrP] = r; expEdge[wrP] = e; expTag[wrP] = tag; wrP++;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic look(input int a, input string tag);
    step(1, mkKey(a), 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic load(input int st, input bit id, input bit pt, input bit we, input int a, input int d);
    step(0, '0, 0, 0, 1, st, id, pt, we, a, d, "load");
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 8; a++) look(a, tag);
  endtask

  // Result monitor: order, content and exact latency (R2)
  always @(negedge clk) begin
    if (monOn && resultValid) begin
      if (rdP >= wrP) begin
        check(0, "R6 unexpected result", resultData, 0);
      end else begin
        check(resultData == expQ[rdP], {expTag[rdP], " R2 data"}, resultData, expQ[rdP]);
        check(edgeCnt == expEdge[rdP] + NS, {expTag[rdP], " R2 latency"}, 32'(edgeCnt), 32'(expEdge[rdP] + NS));
        rdP++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NS; j++) begin
      for (int a = 0; a < 8; a++) mm[j][a] = '0;
      for (int i = 0; i < 2; i++)
        for (int p = 0; p < 2; p++) begin
          mtWe[j][i][p] = 0; mtAddr[j][i][p] = 0; mtData[j][i][p] = '0;
        end
    end
    rstN = 0; lookupValid = 0; lookupKey = '0; bubbleReq = 0; bubbleId = 0;
    loadValid = 0; loadStage = 0; loadId = 0; loadPort = 0; loadWe = 0;
    loadAddr = '0; loadData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(resultValid == 0, "R1 reset resultValid", 32'(resultValid), 0);
    check(resultData == 0, "R1 reset resultData", resultData, 0);
    monOn = 1;
    sweep("R1 zero memories");
    // A bubble with empty tables must change nothing (R1 cleared enables)
    step(0, '0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 empty bubble");
    sweep("R1 after empty bubble");

    // Entry 0: distinct addresses; stage 2 port 1 disabled (R5)
    for (int j = 0; j < NS; j++) begin
      load(j, 0, 0, 1, j, 8'h10 + j);
      load(j, 0, 1, (j != 2), (j + 3) & 7, (j == 2) ? 8'hEE : 8'h80 + j);
    end
    // Entry 1: both ports hit address 5 (R9); stage 3 fully disabled (R5)
    for (int j = 0; j < NS; j++) begin
      load(j, 1, 0, (j != 3), 5, 8'h40 + j);
      load(j, 1, 1, (j != 3), 5, 8'h60 + j);
    end
    sweep("R5 tables loaded no effect yet");

    // Stream with bubbles mid-flow; lookup coinciding with a bubble is dropped
    for (int t = 0; t < 24; t++) begin
      if (t == 6)       step(0, '0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 bubble id0");
      else if (t == 14) step(1, mkKey(t), 1, 1, 0, 0, 0, 0, 0, 0, 0, "R6 bubble with lookup");
      else              look(t, "R4 R3 stream");
    end
    sweep("R9 R5 R8 after both bubbles");

    // Loads during flight: stage 3 rejected, stage 0 accepted, window edges
    step(1, mkKey(2), 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 bubble id0 again");
    step(1, mkKey(3), 0, 0, 1, 3, 0, 0, 1, 7, 8'hAA, "R7 stage3 during flight");
    step(1, mkKey(4), 0, 0, 1, 2, 1, 0, 1, 1, 8'h5A, "R7 stage2 at window end");
    step(1, mkKey(5), 0, 0, 1, 0, 1, 0, 1, 6, 8'h33, "R7 stage0 after pass");
    step(1, mkKey(6), 0, 0, 1, 1, 1, 0, 1, 2, 8'h77, "R7 stage1 after pass");
    idle(2);
    sweep("R7 before id1 reuse");
    step(0, '0, 1, 1, 1, 0, 0, 0, 1, 4, 8'h99, "R7 same-cycle load rejected");
    sweep("R8 after id1 reuse");

    // Back-to-back bubbles of both identifiers surrounded by lookups
    look(1, "R8 ahead");
    step(0, '0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 bubble id0");
    step(0, '0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R8 bubble id1");
    for (int t = 0; t < 8; t++) look(t, "R8 behind");
    idle(NS + 4);
    check(rdP == wrP, "R6 no lookup lost or stalled", 32'(rdP), 32'(wrP));
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule